// File: doc/BRIEF.md
# Sector Group Protection Register

This block keeps one protection flag for each sector group of a behavioural flash model. Program and erase requests come in with a group number. A request that names a protected group is refused at once, so the memory beside this block is never written. Software or a programmer sets the flags one group at a time. A separate chip-unprotect operation clears every flag together.

Both operations commit only when a full write-strobe pulse is seen while the decoded mode holds still. The pulse must go low and then high again. A pulse cut short by the device reset, or by a change of mode, leaves the flags as they were. A readout path returns the flag of the selected group on bit 0, with the other seven bits zero, when address bit A1 is high. When A1 is low it returns one of two identification codes. This path works in two modes: the high-voltage verify mode and the in-system identification mode.

The strobe sequencer has three states. In `ST_IDLE`, a falling strobe moves it to `ST_PROT_LOW` if the mode is protect, or to `ST_UNPROT_LOW` if the mode is unprotect. The group number is captured on that same edge. From either low state, a rising strobe commits the operation and returns to `ST_IDLE`. A mode change or a device reset returns to `ST_IDLE` with nothing committed.

Top module: `sgp_guard`

## Requirements
- R1: After power-on reset (`por_n` low) every flag is clear. A verify read with A1 = 1 returns 00h for every group.
- R2: `req_allow` is 1 exactly when `req_valid` is 1 and group `req_grp` is unprotected. It is 0 for a protected group, and 0 whenever `req_valid` is 0.
- R3: In protect mode (`mode` = 1), a complete strobe sets the flag of the group given at the falling edge. The flag becomes visible in the cycle after the rising edge is sampled. While the strobe is still low, the flag keeps its old value.
- R4: In unprotect mode (`mode` = 2), a complete strobe clears every flag at once.
- R5: In verify mode (`mode` = 3) with A1 = 1, the read byte is 01h for a protected group and 00h for an unprotected group.
- R6: In verify mode with A1 = 0, the read byte is `MFR_CODE` when A0 = 0 and `DEV_CODE` when A0 = 1. The group address has no effect on it.
- R7: In identification mode (`mode` = 4), the read byte is exactly what verify mode would return for the same A1, A0 and group.
- R8: A strobe that is interrupted leaves every flag unchanged. This covers a low `dev_rst_n` between the edges, and a change of `mode` between the edges.
- R9: In array mode (`mode` = 0), and during protect and unprotect, the read byte is 00h.
- R10: Changing `grp_addr` while the strobe is low has no effect on which group a protect strobe sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all flags |
| dev_rst_n | input | 1 | Synchronous device reset, active low; aborts a strobe, keeps flags |
| mode | input | 3 | 0 array, 1 protect, 2 unprotect, 3 verify, 4 identification |
| we_n | input | 1 | Write strobe, active low, sampled on `clk` |
| grp_addr | input | $clog2(NUM_GROUPS) | Group select for protect and for readout |
| addr_a1 | input | 1 | Selects status (1) or identification code (0) |
| addr_a0 | input | 1 | Selects device code (1) or manufacturer code (0) |
| req_valid | input | 1 | A program or erase request is presented |
| req_grp | input | $clog2(NUM_GROUPS) | Group that the request targets |
| rd_data | output | 8 | Readout byte |
| req_allow | output | 1 | Request may proceed |

## Verification
The assertions assume three things about the inputs. `we_n` is a level that is sampled on `clk`. `mode` is only meaningful to the sequencer while a pulse is in progress. `dev_rst_n` stays high except where an abort is meant. The stimulus changes every input only on the falling clock edge. It holds `mode` steady across each strobe, except in the cases that deliberately break a pulse. It keeps every group number within `NUM_GROUPS`, so no assertion sees an index outside the flag vector.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
    typedef enum logic [2:0] {
        MODE_ARRAY     = 3'd0,
        MODE_PROTECT   = 3'd1,
        MODE_UNPROTECT = 3'd2,
        MODE_VERIFY    = 3'd3,
        MODE_ID        = 3'd4
    } sgp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PROT_LOW   = 2'd1,
        ST_UNPROT_LOW = 2'd2
    } sgp_state_e;
endpackage

// File: rtl/sgp_strobe_fsm.sv
module sgp_strobe_fsm
    import sgp_pkg::*;
#(
    parameter int GW = 3
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          dev_rst_n,
    input  logic [2:0]    mode,
    input  logic          we_n,
    input  logic [GW-1:0] grp_in,
    output logic          set_en,
    output logic          clr_en,
    output logic [GW-1:0] set_grp
);
    sgp_state_e    st_q, st_d;
    sgp_mode_e     mode_e;
    logic          we_q;
    logic          fall, rise;
    logic [GW-1:0] grp_q;

    assign mode_e = sgp_mode_e'(mode);
    assign fall   = we_q & ~we_n;
    assign rise   = ~we_q & we_n;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            we_q  <= 1'b1;
            st_q  <= ST_IDLE;
            grp_q <= '0;
        end else begin
            we_q <= we_n;
            st_q <= st_d;
            if (st_q == ST_IDLE && fall) grp_q <= grp_in;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (fall && mode_e == MODE_PROTECT)        st_d = ST_PROT_LOW;
                else if (fall && mode_e == MODE_UNPROTECT) st_d = ST_UNPROT_LOW;
            end
            ST_PROT_LOW: begin
                if (mode_e != MODE_PROTECT || rise)        st_d = ST_IDLE;
            end
            ST_UNPROT_LOW: begin
                if (mode_e != MODE_UNPROTECT || rise)      st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (!dev_rst_n) st_d = ST_IDLE;
    end

    always_comb begin
        set_en  = dev_rst_n && rise && st_q == ST_PROT_LOW   && mode_e == MODE_PROTECT;
        clr_en  = dev_rst_n && rise && st_q == ST_UNPROT_LOW && mode_e == MODE_UNPROTECT;
        set_grp = grp_q;
    end

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q != ST_IDLE |-> $past(dev_rst_n));

    // R10
    grp_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_PROT_LOW && $past(st_q) == ST_PROT_LOW) |-> $stable(grp_q));
endmodule

// File: rtl/sgp_mask_reg.sv
module sgp_mask_reg #(
    parameter int NUM_GROUPS = 8,
    parameter int GW         = 3
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  set_en,
    input  logic                  clr_en,
    input  logic [GW-1:0]         set_grp,
    output logic [NUM_GROUPS-1:0] mask_q
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                               bit_q <= 1'b0;
            else if (clr_en)                          bit_q <= 1'b0;
            else if (set_en && set_grp == GW'(g))     bit_q <= 1'b1;
        end
        assign mask_q[g] = bit_q;
    end

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr_en |=> mask_q == '0);

    // R3
    set_one_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_en |=> mask_q[$past(set_grp)]);

    // R3
    only_on_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mask_q != $past(mask_q)) |-> $past(set_en || clr_en));
endmodule

// File: rtl/sgp_readout.sv
module sgp_readout
    import sgp_pkg::*;
#(
    parameter int         NUM_GROUPS = 8,
    parameter int         GW         = 3,
    parameter logic [7:0] MFR_CODE   = 8'h5A,
    parameter logic [7:0] DEV_CODE   = 8'hA3
) (
    input  logic [2:0]            mode,
    input  logic                  addr_a1,
    input  logic                  addr_a0,
    input  logic [GW-1:0]         rd_grp,
    input  logic [NUM_GROUPS-1:0] mask_q,
    output logic [7:0]            rd_data
);
    sgp_mode_e mode_e;
    logic      flag;

    assign mode_e = sgp_mode_e'(mode);

    always_comb begin
        flag = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (rd_grp == GW'(g)) flag = mask_q[g];
    end

    always_comb begin
        rd_data = 8'h00;
        unique case (mode_e)
            MODE_VERIFY, MODE_ID: begin
                if (addr_a1)      rd_data = {7'b0, flag};
                else if (addr_a0) rd_data = DEV_CODE;
                else              rd_data = MFR_CODE;
            end
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/sgp_guard.sv
module sgp_guard
    import sgp_pkg::*;
#(
    parameter int         NUM_GROUPS = 8,
    parameter logic [7:0] MFR_CODE   = 8'h5A,
    parameter logic [7:0] DEV_CODE   = 8'hA3,
    localparam int        GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          dev_rst_n,
    input  logic [2:0]    mode,
    input  logic          we_n,
    input  logic [GW-1:0] grp_addr,
    input  logic          addr_a1,
    input  logic          addr_a0,
    input  logic          req_valid,
    input  logic [GW-1:0] req_grp,
    output logic [7:0]    rd_data,
    output logic          req_allow
);
    logic                  set_en, clr_en;
    logic [GW-1:0]         set_grp;
    logic [NUM_GROUPS-1:0] mask_q;
    logic                  req_prot;

    sgp_strobe_fsm #(.GW(GW)) u_fsm (
        .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .mode(mode),
        .we_n(we_n), .grp_in(grp_addr),
        .set_en(set_en), .clr_en(clr_en), .set_grp(set_grp)
    );

    sgp_mask_reg #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_mask (
        .clk(clk), .por_n(por_n), .set_en(set_en), .clr_en(clr_en),
        .set_grp(set_grp), .mask_q(mask_q)
    );

    sgp_readout #(.NUM_GROUPS(NUM_GROUPS), .GW(GW),
                  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
        .mode(mode), .addr_a1(addr_a1), .addr_a0(addr_a0),
        .rd_grp(grp_addr), .mask_q(mask_q), .rd_data(rd_data)
    );

    always_comb begin
        req_prot = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (req_grp == GW'(g)) req_prot = mask_q[g];
        req_allow = req_valid & ~req_prot;
    end

    // R8
    dev_rst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !dev_rst_n |=> $stable(mask_q));

    // R2
    refuse_after_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(set_en) && req_valid && req_grp == $past(set_grp)) |-> !req_allow);

    // R5
    status_byte_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((mode == 3'd3 || mode == 3'd4) && addr_a1) |-> rd_data[7:1] == 7'd0);

    // R9
    array_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode <= 3'd2) |-> rd_data == 8'h00);
endmodule

// File: tb/tb_sgp_guard.sv
`timescale 1ns/1ps
module tb_sgp_guard;
    localparam int         NG  = 8;
    localparam int         GW  = 3;
    localparam logic [7:0] MFR = 8'h5A;
    localparam logic [7:0] DEV = 8'hA3;

    logic          clk = 1'b0;
    logic          por_n, dev_rst_n, we_n, addr_a1, addr_a0, req_valid;
    logic [2:0]    mode;
    logic [GW-1:0] grp_addr, req_grp;
    logic [7:0]    rd_data;
    logic          req_allow;
    logic [NG-1:0] exp_mask;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    sgp_guard #(.NUM_GROUPS(NG), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
        .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .mode(mode),
        .we_n(we_n), .grp_addr(grp_addr), .addr_a1(addr_a1), .addr_a0(addr_a0),
        .req_valid(req_valid), .req_grp(req_grp),
        .rd_data(rd_data), .req_allow(req_allow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sweep of all groups: R5 status, R7 id mode, R2 allow, R9 array mode
    task automatic sweep(input string req);
        for (int g = 0; g < NG; g++) begin
            @(negedge clk);
            mode = 3'd3; addr_a1 = 1'b1; grp_addr = GW'(g);
            req_valid = 1'b1; req_grp = GW'(g);
            #1;
            chk(rd_data == {7'b0, exp_mask[g]}, {req, " R5"}, rd_data, exp_mask[g]);
            chk(req_allow == !exp_mask[g], {req, " R2"}, req_allow, !exp_mask[g]);
            mode = 3'd4; #1;
            chk(rd_data == {7'b0, exp_mask[g]}, {req, " R7"}, rd_data, exp_mask[g]);
            mode = 3'd0; #1;
            chk(rd_data == 8'h00, {req, " R9"}, rd_data, 0);
            req_valid = 1'b0; #1;
            chk(req_allow == 1'b0, {req, " R2 idle"}, req_allow, 0);
        end
    endtask

    task automatic strobe(input logic [2:0] m, input int g, input int low_cyc);
        @(negedge clk);
        mode = m; grp_addr = GW'(g); we_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        por_n = 0; dev_rst_n = 1; mode = 3'd0; we_n = 1;
        grp_addr = '0; addr_a1 = 0; addr_a0 = 0; req_valid = 0; req_grp = '0;
        exp_mask = '0;
        repeat (3) @(negedge clk);
        por_n = 1;

        // R1 reset state
        sweep("R1");

        // R6 / R7 id codes for every group and both id modes
        for (int m = 3; m <= 4; m++)
            for (int g = 0; g < NG; g++) begin
                @(negedge clk);
                mode = 3'(m); addr_a1 = 0; grp_addr = GW'(g);
                addr_a0 = 0; #1;
                chk(rd_data == MFR, (m == 3) ? "R6 mfr" : "R7 mfr", rd_data, MFR);
                addr_a0 = 1; #1;
                chk(rd_data == DEV, (m == 3) ? "R6 dev" : "R7 dev", rd_data, DEV);
            end
        addr_a0 = 0;

        // R3 flag holds during low phase; R10 address moves while low
        @(negedge clk);
        mode = 3'd1; grp_addr = 3'd5; we_n = 0; req_valid = 1; req_grp = 3'd5;
        @(negedge clk);
        grp_addr = 3'd2;
        @(negedge clk);
        chk(req_allow == 1'b1, "R3 low phase", req_allow, 1);
        chk(rd_data == 8'h00, "R9 protect mode", rd_data, 0);
        we_n = 1;
        @(negedge clk);
        exp_mask[5] = 1'b1;
        chk(req_allow == 1'b0, "R3 after rise", req_allow, 0);
        req_grp = 3'd2; #1;
        chk(req_allow == 1'b1, "R10 group not moved", req_allow, 1);
        req_valid = 0;
        sweep("R3");

        // R8 aborted by device reset
        @(negedge clk);
        mode = 3'd1; grp_addr = 3'd3; we_n = 0;
        @(negedge clk); dev_rst_n = 0;
        @(negedge clk); dev_rst_n = 1;
        @(negedge clk); we_n = 1;
        @(negedge clk);
        sweep("R8 rst");

        // R8 aborted by mode change
        @(negedge clk);
        mode = 3'd1; grp_addr = 3'd1; we_n = 0;
        @(negedge clk); mode = 3'd3;
        @(negedge clk); mode = 3'd1; we_n = 1;
        @(negedge clk);
        sweep("R8 mode");

        // R8 unprotect aborted by reset
        @(negedge clk);
        mode = 3'd2; we_n = 0;
        @(negedge clk); dev_rst_n = 0;
        @(negedge clk); dev_rst_n = 1; we_n = 1;
        @(negedge clk);
        sweep("R8 unprot");

        // protect every group in turn
        for (int g = 0; g < NG; g++) begin
            strobe(3'd1, g, 1 + (g % 3));
            exp_mask[g] = 1'b1;
            sweep("R3 walk");
        end

        // R4 chip unprotect clears all
        strobe(3'd2, 0, 2);
        exp_mask = '0;
        sweep("R4");

        // R4 after partial pattern
        strobe(3'd1, 6, 1); exp_mask[6] = 1;
        strobe(3'd1, 0, 1); exp_mask[0] = 1;
        sweep("R3 pattern");
        strobe(3'd2, 7, 1); exp_mask = '0;
        sweep("R4 again");

        finish_run();
    end
endmodule